// File: doc/BRIEF.md
# Partial-Address Store-Load Alias Checker

This block keeps the addresses of stores that have issued but not yet committed, in program order, and screens every younger load against them. The screen runs in two passes. The quick pass looks only at the low page-offset bits of the addresses, so it can run before address translation has finished. Because it ignores the page number, two addresses an exact multiple of 4096 bytes apart look the same to it. The slower pass runs one cycle later. It repeats the comparison on the full address, but only for the stores that the quick pass flagged.

The outcome of a lookup is one of three cases. A true overlap names the youngest older store that the load touches. A false alias is a page-offset match with no real overlap; it raises a one-cycle pulse and asks the load pipeline to replay for a fixed number of cycles. A saturating counter tallies the false aliases. Stores go into the queue at the tail without being compared to anything, and they leave from the head when they commit. The alias check belongs to loads only.

Top module: `sq_alias_check`

## Requirements
- R1: The queue holds 8 stores. A store is accepted at the tail only when the queue is not full, and an allocate request while full is dropped. A commit frees the oldest entry, and a commit while empty is ignored. `sq_full_o` and `sq_empty_o` show the occupancy after each clock edge.
- R2: An access covers 2^size bytes, with size being `st_size_i` or `ld_size_i` (0 = 1 byte, up to 3 = 8 bytes), at its address with the low size bits cleared. The quick pass flags a queued store when the two blocks overlap within address bits 11:0. Bits above 11 play no part.
- R3: A load whose address differs from a queued store's address by a nonzero multiple of 4096 (same size) raises `fast_hit_o` and `false_alias_o`, and does not raise `true_hit_o`.
- R4: Stores are accepted with no comparison against other stores. A cycle stream of allocates and commits with no load never raises `fast_hit_o`, `true_hit_o` or `false_alias_o`.
- R5: For a load presented in cycle T, `fast_hit_o`, `true_hit_o`, `true_idx_o` and `false_alias_o` show its result in cycle T+2, each as a single-cycle pulse. In every other cycle they are low.
- R6: When the full-address comparison finds an overlap, `true_hit_o` is raised and `true_idx_o` gives the slot of the youngest matching older store. Slots are numbered from 0 for the first store after reset and rise by one, modulo 8, with each accepted store.
- R7: A false alias raises `false_alias_o` for one cycle and `replay_o` for 3 cycles, starting in the same cycle. A new false alias restarts the 3-cycle window.
- R8: `alias_cnt_o` rises by one in the cycle after each false-alias pulse and holds at 15 once it reaches 15.
- R9: A store that commits in the same cycle as a load lookup takes no part in that load's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_alloc_i | input | 1 | Allocate a store at the tail |
| st_addr_i | input | 32 | Store byte address |
| st_size_i | input | 2 | Store size, log2 bytes |
| st_commit_i | input | 1 | Free the oldest store |
| ld_valid_i | input | 1 | Load lookup request |
| ld_addr_i | input | 32 | Load byte address |
| ld_size_i | input | 2 | Load size, log2 bytes |
| sq_full_o | output | 1 | Queue holds 8 stores |
| sq_empty_o | output | 1 | Queue holds no store |
| fast_hit_o | output | 1 | Page-offset match found |
| true_hit_o | output | 1 | Full-address overlap found |
| true_idx_o | output | 3 | Slot of youngest overlapping store |
| false_alias_o | output | 1 | Offset match with no real overlap |
| replay_o | output | 1 | Load replay request window |
| alias_cnt_o | output | 4 | Saturating false-alias count |

## Verification
The case that is hardest to reach from the ports is a store that leaves the queue in the very cycle its lookup is screened. To produce it, the bench leaves one matching store at the head and then issues a commit and a load in the same cycle. The youngest-store choice also needs deliberate setup: the bench places duplicate addresses in several slots and sets up sizes so that blocks overlap only partially. Saturating the counter takes a long run of back-to-back false aliases. These also check that the replay window restarts correctly.

// File: rtl/sac_pkg.sv
package sac_pkg;
   localparam int unsigned DEF_DEPTH  = 8;
   localparam int unsigned DEF_AW     = 32;
   localparam int unsigned DEF_SZW    = 2;
   localparam int unsigned DEF_PG     = 12;
   localparam int unsigned DEF_CNT_W  = 4;
   localparam int unsigned DEF_REPLAY = 3;

   // Two power-of-two aligned blocks overlap when their addresses agree
   // above the larger block size; keep selects which address bits count.
   function automatic logic sac_meet(input logic [63:0] a,
                                     input logic [63:0] b,
                                     input logic [63:0] keep,
                                     input int unsigned sa,
                                     input int unsigned sb);
      int unsigned mx;
      logic [63:0] d;
      mx = (sa > sb) ? sa : sb;
      d  = (a ^ b) & keep;
      return ((d >> mx) == 64'd0);
   endfunction
endpackage

// File: rtl/sac_ring.sv
module sac_ring #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned SZW   = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            alloc_i,
   input  logic [AW-1:0]                   alloc_addr_i,
   input  logic [SZW-1:0]                  alloc_size_i,
   input  logic                            commit_i,
   output logic [DEPTH-1:0][AW-1:0]        ent_addr_o,
   output logic [DEPTH-1:0][SZW-1:0]       ent_size_o,
   output logic [DEPTH-1:0]                ent_vld_o,
   output logic [$clog2(DEPTH)-1:0]        tail_o,
   output logic [DEPTH-1:0]                commit_oh_o,
   output logic                            full_o,
   output logic                            empty_o
);
   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [PW-1:0]              head_q, tail_q;
   logic [CW-1:0]              cnt_q;
   logic [DEPTH-1:0]           vld_q;
   logic [DEPTH-1:0][AW-1:0]   addr_q;
   logic [DEPTH-1:0][SZW-1:0]  size_q;
   logic                       do_alloc, do_commit;

   assign full_o    = (cnt_q == CW'(DEPTH));
   assign empty_o   = (cnt_q == '0);
   assign do_alloc  = alloc_i && !full_o;
   assign do_commit = commit_i && !empty_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
         vld_q  <= '0;
      end else begin
         if (do_commit) begin
            vld_q[head_q] <= 1'b0;
            head_q        <= head_q + 1'b1;
         end
         if (do_alloc) begin
            vld_q[tail_q] <= 1'b1;
            tail_q        <= tail_q + 1'b1;
         end
         cnt_q <= cnt_q + CW'(do_alloc) - CW'(do_commit);
      end
   end

   always_ff @(posedge clk) begin
      if (do_alloc) begin
         addr_q[tail_q] <= alloc_addr_i;
         size_q[tail_q] <= alloc_size_i;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign commit_oh_o[g] = do_commit && (head_q == PW'(g));
   end

   assign ent_addr_o = addr_q;
   assign ent_size_o = size_q;
   assign ent_vld_o  = vld_q;
   assign tail_o     = tail_q;
endmodule

// File: rtl/sac_pagecmp.sv
module sac_pagecmp
   import sac_pkg::*;
#(
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned AW      = 32,
   parameter int unsigned SZW     = 2,
   parameter int unsigned PG_BITS = 12
) (
   input  logic                       ld_vld_i,
   input  logic [AW-1:0]              ld_addr_i,
   input  logic [SZW-1:0]             ld_size_i,
   input  logic [DEPTH-1:0][AW-1:0]   ent_addr_i,
   input  logic [DEPTH-1:0][SZW-1:0]  ent_size_i,
   input  logic [DEPTH-1:0]           ent_vld_i,
   output logic [DEPTH-1:0]           hit_vec_o
);
   localparam logic [63:0] PG_KEEP = (64'd1 << PG_BITS) - 64'd1;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_vec_o[g] = ld_vld_i && ent_vld_i[g] &&
                            sac_meet(64'(ent_addr_i[g]), 64'(ld_addr_i), PG_KEEP,
                                     int'(ent_size_i[g]), int'(ld_size_i));
   end
endmodule

// File: rtl/sac_fullchk.sv
module sac_fullchk
   import sac_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned SZW   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [DEPTH-1:0]           hit_vec_i,
   input  logic [DEPTH-1:0]           commit_oh_i,
   input  logic [AW-1:0]              ld_addr_i,
   input  logic [SZW-1:0]             ld_size_i,
   input  logic [DEPTH-1:0][AW-1:0]   ent_addr_i,
   input  logic [DEPTH-1:0][SZW-1:0]  ent_size_i,
   input  logic [$clog2(DEPTH)-1:0]   tail_i,
   output logic                       fast_hit_o,
   output logic                       true_hit_o,
   output logic [$clog2(DEPTH)-1:0]   true_idx_o,
   output logic                       false_alias_o
);
   localparam int unsigned PW = $clog2(DEPTH);
   localparam logic [63:0] ALL_KEEP = {64{1'b1}};

   logic [DEPTH-1:0]  mask_q, full_vec;
   logic [AW-1:0]     la_q;
   logic [SZW-1:0]    ls_q;
   logic              found;
   logic [PW-1:0]     pick;
   logic              fast_q, true_q, false_q;
   logic [PW-1:0]     idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= hit_vec_i & ~commit_oh_i;
   end

   always_ff @(posedge clk) begin
      la_q <= ld_addr_i;
      ls_q <= ld_size_i;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_full
      assign full_vec[g] = mask_q[g] &&
                           sac_meet(64'(ent_addr_i[g]), 64'(la_q), ALL_KEEP,
                                    int'(ent_size_i[g]), int'(ls_q));
   end

   // Scan from oldest to youngest so the youngest match is kept last.
   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int k = DEPTH; k >= 1; k--) begin
         if (full_vec[tail_i - PW'(k)]) begin
            found = 1'b1;
            pick  = tail_i - PW'(k);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fast_q  <= 1'b0;
         true_q  <= 1'b0;
         false_q <= 1'b0;
         idx_q   <= '0;
      end else begin
         fast_q  <= |mask_q;
         true_q  <= found;
         false_q <= (|mask_q) && !found;
         idx_q   <= pick;
      end
   end

   assign fast_hit_o    = fast_q;
   assign true_hit_o    = true_q;
   assign true_idx_o    = idx_q;
   assign false_alias_o = false_q;
endmodule

// File: rtl/sac_replay.sv
module sac_replay #(
   parameter int unsigned REPLAY_CYC = 3,
   parameter int unsigned CNT_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              false_i,
   output logic              replay_o,
   output logic [CNT_W-1:0]  cnt_o
);
   logic [CNT_W-1:0] cnt_q;

   if (REPLAY_CYC == 1) begin : g_single
      assign replay_o = false_i;
   end else begin : g_multi
      localparam int unsigned RW = $clog2(REPLAY_CYC);
      logic [RW-1:0] rc_q;
      always_ff @(posedge clk) begin
         if (!rst_n)             rc_q <= '0;
         else if (false_i)       rc_q <= RW'(REPLAY_CYC - 1);
         else if (rc_q != '0)    rc_q <= rc_q - 1'b1;
      end
      assign replay_o = false_i || (rc_q != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (false_i && (cnt_q != '1))  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/sq_alias_check.sv
module sq_alias_check
   import sac_pkg::*;
#(
   parameter int unsigned DEPTH      = DEF_DEPTH,
   parameter int unsigned AW         = DEF_AW,
   parameter int unsigned SZW        = DEF_SZW,
   parameter int unsigned PG_BITS    = DEF_PG,
   parameter int unsigned CNT_W      = DEF_CNT_W,
   parameter int unsigned REPLAY_CYC = DEF_REPLAY
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      st_alloc_i,
   input  logic [AW-1:0]             st_addr_i,
   input  logic [SZW-1:0]            st_size_i,
   input  logic                      st_commit_i,
   input  logic                      ld_valid_i,
   input  logic [AW-1:0]             ld_addr_i,
   input  logic [SZW-1:0]            ld_size_i,
   output logic                      sq_full_o,
   output logic                      sq_empty_o,
   output logic                      fast_hit_o,
   output logic                      true_hit_o,
   output logic [$clog2(DEPTH)-1:0]  true_idx_o,
   output logic                      false_alias_o,
   output logic                      replay_o,
   output logic [CNT_W-1:0]          alias_cnt_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (AW > 64 || PG_BITS == 0 || PG_BITS >= AW) begin : g_bad_aw
      $error("PG_BITS must lie below AW and AW must not exceed 64");
   end
   if (REPLAY_CYC < 1 || CNT_W < 1) begin : g_bad_cnt
      $error("REPLAY_CYC and CNT_W must be at least 1");
   end

   localparam int unsigned PW = $clog2(DEPTH);

   logic [DEPTH-1:0][AW-1:0]   ent_addr;
   logic [DEPTH-1:0][SZW-1:0]  ent_size;
   logic [DEPTH-1:0]           ent_vld;
   logic [PW-1:0]              tail;
   logic [DEPTH-1:0]           commit_oh;
   logic [DEPTH-1:0]           hit_vec;

   sac_ring #(.DEPTH(DEPTH), .AW(AW), .SZW(SZW)) u_ring (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (st_alloc_i),
      .alloc_addr_i (st_addr_i),
      .alloc_size_i (st_size_i),
      .commit_i     (st_commit_i),
      .ent_addr_o   (ent_addr),
      .ent_size_o   (ent_size),
      .ent_vld_o    (ent_vld),
      .tail_o       (tail),
      .commit_oh_o  (commit_oh),
      .full_o       (sq_full_o),
      .empty_o      (sq_empty_o)
   );

   sac_pagecmp #(.DEPTH(DEPTH), .AW(AW), .SZW(SZW), .PG_BITS(PG_BITS)) u_page (
      .ld_vld_i   (ld_valid_i),
      .ld_addr_i  (ld_addr_i),
      .ld_size_i  (ld_size_i),
      .ent_addr_i (ent_addr),
      .ent_size_i (ent_size),
      .ent_vld_i  (ent_vld),
      .hit_vec_o  (hit_vec)
   );

   sac_fullchk #(.DEPTH(DEPTH), .AW(AW), .SZW(SZW)) u_full (
      .clk           (clk),
      .rst_n         (rst_n),
      .hit_vec_i     (hit_vec),
      .commit_oh_i   (commit_oh),
      .ld_addr_i     (ld_addr_i),
      .ld_size_i     (ld_size_i),
      .ent_addr_i    (ent_addr),
      .ent_size_i    (ent_size),
      .tail_i        (tail),
      .fast_hit_o    (fast_hit_o),
      .true_hit_o    (true_hit_o),
      .true_idx_o    (true_idx_o),
      .false_alias_o (false_alias_o)
   );

   sac_replay #(.REPLAY_CYC(REPLAY_CYC), .CNT_W(CNT_W)) u_replay (
      .clk      (clk),
      .rst_n    (rst_n),
      .false_i  (false_alias_o),
      .replay_o (replay_o),
      .cnt_o    (alias_cnt_o)
   );
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned REPLAY_CYC = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_valid_i,
   input logic              sq_full_o,
   input logic              sq_empty_o,
   input logic              fast_hit_o,
   input logic              true_hit_o,
   input logic              false_alias_o,
   input logic              replay_o,
   input logic [CNT_W-1:0]  alias_cnt_o
);
   logic ld_d1, ld_d2;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_d1 <= 1'b0;
         ld_d2 <= 1'b0;
      end else begin
         ld_d1 <= ld_valid_i;
         ld_d2 <= ld_d1;
      end
   end

   p_occupancy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(sq_full_o && sq_empty_o));

   p_load_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fast_hit_o |-> ld_d2);

   p_verdict_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (true_hit_o || false_alias_o) |-> fast_hit_o);

   p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(true_hit_o && false_alias_o));

   p_replay_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      false_alias_o |-> replay_o);

   if (REPLAY_CYC >= 2) begin : g_hold
      p_replay_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         false_alias_o |=> replay_o);
   end

   p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (alias_cnt_o == {CNT_W{1'b1}}) |=> (alias_cnt_o == {CNT_W{1'b1}}));

   p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(alias_cnt_o) |-> (alias_cnt_o == CNT_W'($past(alias_cnt_o) + 1'b1)));
endmodule

bind sq_alias_check sac_checker #(.CNT_W(CNT_W), .REPLAY_CYC(REPLAY_CYC)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ld_valid_i    (ld_valid_i),
   .sq_full_o     (sq_full_o),
   .sq_empty_o    (sq_empty_o),
   .fast_hit_o    (fast_hit_o),
   .true_hit_o    (true_hit_o),
   .false_alias_o (false_alias_o),
   .replay_o      (replay_o),
   .alias_cnt_o   (alias_cnt_o)
);

// File: tb/sq_alias_check_test.sv
module sq_alias_check_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_alloc_i = 1'b0, st_commit_i = 1'b0, ld_valid_i = 1'b0;
   logic [31:0] st_addr_i = '0, ld_addr_i = '0;
   logic [1:0]  st_size_i = '0, ld_size_i = '0;
   logic        sq_full_o, sq_empty_o, fast_hit_o, true_hit_o, false_alias_o, replay_o;
   logic [2:0]  true_idx_o;
   logic [3:0]  alias_cnt_o;

   sq_alias_check uut (.*);

   always #(CLK_P/2) clk = ~clk;

   typedef struct {int due; bit fh; bit th; int idx; bit fa; string tag;} exp_t;
   exp_t exp_q[$];

   int total = 0, fails = 0, cyc = 0, rep_left = 0, cnt_exp = 0;
   bit mon_on = 0, done = 0;
   logic [31:0] m_addr [8];
   int m_size [8];
   int m_head = 0, m_tail = 0, m_cnt = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   function automatic bit meets(input logic [31:0] a, input int sa,
                                input logic [31:0] b, input int sb, input bit page_only);
      int mx;
      logic [31:0] d;
      mx = (sa > sb) ? sa : sb;
      d  = a ^ b;
      if (page_only) d = d & 32'h0000_0FFF;
      return ((d >> mx) == 32'd0);
   endfunction

   // Driver: one cycle of stimulus, expectation pushed to the scoreboard.
   task automatic step(input bit al, input logic [31:0] sa, input int ss, input bit cm,
                       input bit ld, input logic [31:0] la, input int ls, input string tag);
      exp_t e;
      int pre_cnt;
      st_alloc_i = al; st_addr_i = sa; st_size_i = 2'(ss);
      st_commit_i = cm;
      ld_valid_i = ld; ld_addr_i = la; ld_size_i = 2'(ls);
      if (ld) begin
         e.due = cyc + 2; e.fh = 0; e.th = 0; e.idx = 0; e.fa = 0; e.tag = tag;
         for (int k = 1; k <= m_cnt; k++) begin
            int slot;
            slot = (m_tail - k + 8) % 8;
            if (cm && slot == m_head) continue;
            if (meets(m_addr[slot], m_size[slot], la, ls, 1'b1)) e.fh = 1;
            if (!e.th && meets(m_addr[slot], m_size[slot], la, ls, 1'b0)) begin
               e.th = 1; e.idx = slot;
            end
         end
         e.fa = e.fh && !e.th;
         exp_q.push_back(e);
      end
      pre_cnt = m_cnt;
      if (cm && pre_cnt > 0) begin
         m_head = (m_head + 1) % 8; m_cnt--;
      end
      if (al && pre_cnt < 8) begin
         m_addr[m_tail] = sa; m_size[m_tail] = ss;
         m_tail = (m_tail + 1) % 8; m_cnt++;
      end
      @(negedge clk);
      chk("R1 full", sq_full_o, (m_cnt == 8));
      chk("R1 empty", sq_empty_o, (m_cnt == 0));
   endtask

   task automatic st(input logic [31:0] a, input int s);
      step(1, a, s, 0, 0, 0, 0, "R1");
   endtask
   task automatic ldk(input logic [31:0] a, input int s, input string tag);
      step(0, 0, 0, 0, 1, a, s, tag);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "R5");
   endtask
   task automatic cmt();
      step(0, 0, 0, 1, 0, 0, 0, "R1");
   endtask

   // Monitor: pops scoreboard items as results come due.
   always @(negedge clk) begin : mon
      exp_t e;
      bit popped_fa;
      if (mon_on) begin
         popped_fa = 0;
         if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            e = exp_q.pop_front();
            chk({e.tag, " fast_hit"}, fast_hit_o, e.fh);
            chk({e.tag, " R6 true_hit"}, true_hit_o, e.th);
            if (e.th) chk("R6 true_idx", true_idx_o, e.idx);
            chk({e.tag, " R3 false_alias"}, false_alias_o, e.fa);
            if (e.fa) begin
               rep_left = 3;
               popped_fa = 1;
            end
         end else begin
            chk("R4 R5 idle fast_hit", fast_hit_o, 0);
            chk("R4 R5 idle true_hit", true_hit_o, 0);
            chk("R4 R5 idle false_alias", false_alias_o, 0);
         end
         chk("R7 replay", replay_o, (rep_left > 0));
         if (rep_left > 0) rep_left--;
         chk("R8 alias_cnt", alias_cnt_o, cnt_exp);
         if (popped_fa && cnt_exp < 15) cnt_exp++;
      end
   end

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R1 reset empty", sq_empty_o, 1);
      chk("R1 reset full", sq_full_o, 0);
      chk("R5 reset flags", {fast_hit_o, true_hit_o, false_alias_o, replay_o}, 0);
      chk("R8 reset count", alias_cnt_o, 0);
      rst_n = 1'b1;
      mon_on = 1;

      // Youngest-match selection and size-aware overlap (R2, R6)
      st(32'h0000_1000, 2);
      st(32'h0000_2004, 2);
      st(32'h0000_3010, 3);
      st(32'h0000_2004, 2);
      ldk(32'h0000_2004, 2, "R6");
      ldk(32'h0000_2006, 1, "R2");
      ldk(32'h0000_3014, 2, "R2");
      ldk(32'h0000_1000, 3, "R2");
      ldk(32'h0000_1008, 2, "R2");
      // False aliases, back to back restarts the window (R3, R7)
      ldk(32'h0000_7004, 2, "R3");
      idle(1);
      ldk(32'h0000_9010, 0, "R3");
      ldk(32'h0012_3004, 2, "R7");
      idle(6);
      // Store-only stream with aliasing addresses (R4)
      for (int i = 0; i < 4; i++) cmt();
      for (int i = 0; i < 12; i++)
         step(1, 32'h0000_1000 * i + 32'h40, 2, (i % 2), 0, 0, 0, "R4");
      idle(4);
      while (m_cnt > 0) cmt();
      // Fill, overflow drop, empty commits (R1)
      for (int i = 0; i < 8; i++) st(32'h0001_0000 + 32'h10 * (i + 1), 2);
      st(32'hABC0_0000, 2);
      ldk(32'hABC0_0000, 2, "R1");
      ldk(32'h0001_0030, 2, "R6");
      idle(3);
      for (int i = 0; i < 10; i++) cmt();
      // Commit in the lookup cycle (R9)
      st(32'h0000_5100, 2);
      step(0, 0, 0, 1, 1, 32'h0000_5100, 2, "R9");
      idle(3);
      st(32'h0000_6100, 2);
      ldk(32'h0000_5100, 2, "R3");
      idle(4);
      // Counter saturation (R8)
      for (int i = 0; i < 18; i++) ldk(32'h0000_8100, 2, "R8");
      idle(8);
      chk("R8 saturated", alias_cnt_o, 15);
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule